// File: doc/BRIEF.md
# Next-Block Instruction Prefetcher with Stream Buffer

This unit sits beside an instruction cache and turns each accepted demand miss into two memory line fetches. The first fetches the missing block, whose data comes back out of the fill port for the cache to store. The second fetches the block a fixed lookahead distance further on. That prefetched line is kept in a small fully associative stream buffer and never reaches the cache directly. A later miss that finds its line in the stream buffer is served from there in one cycle without a memory access. The line is consumed, and the prefetch moves on by the same distance.

A mode input lets the cache's hits trigger prefetches as well as its misses, which gives a one-block-lookahead policy. The prefetch logic avoids wasted traffic in three ways. It does not fetch a line that the buffer already holds or that is already in flight. A queued prefetch that has not been issued is discarded when a new miss arrives. A miss that does not find its line in the buffer flushes the buffer, and the late reply of any prefetch from the old stream is dropped. One demand and one prefetch can be outstanding at the same time, and a 1-bit tag tells their replies apart.

Top module: `nbp_prefetch`

## Requirements
- R1: After reset no memory request and no fill is presented, `acc_ready` is 1 and the stream buffer holds nothing.
- R2: An accepted access with `acc_hit`=0 whose line is not in the stream buffer presents, in the next cycle, a demand request (tag 0) for that line address. `acc_ready` stays 0 until the demand reply (tag 0) arrives. The demand request always goes out before any prefetch request.
- R3: The cycle after a demand reply, `fill_valid` is 1 with the demand line address, the reply data and `fill_from_sb`=0. After that cycle `acc_ready` is 1 again.
- R4: Once the demand request has been taken, a prefetch request (tag 1) for line address b+LOOKAHEAD follows. Its reply is written into the stream buffer and produces no fill.
- R5: An accepted miss whose line is in the stream buffer produces, in the next cycle, a fill from the buffer (`fill_from_sb`=1) with the stored data, and no demand request is made. The buffer entry is consumed, and a prefetch request for b+LOOKAHEAD is presented in that same next cycle.
- R6: A miss not found in the stream buffer flushes every entry. The reply of a prefetch that was outstanding when the flush happened is discarded, so a later miss to that line needs a demand fetch.
- R7: With `obl_en`=1, an accepted access with `acc_hit`=1 requests a prefetch of b+LOOKAHEAD. With `obl_en`=0 such an access produces no request.
- R8: No prefetch is queued when its target line is already valid in the stream buffer or is the address of the outstanding, still current prefetch.
- R9: A prefetch that is queued but not yet issued is discarded when a new buffer-missing miss is accepted. Only the new miss's prefetch is issued afterwards.
- R10: An access presented while `acc_ready`=0 is ignored: it creates no request and does not change the pending fill.
- R11: Line address arithmetic wraps modulo 2^ADDR_W, so b+LOOKAHEAD past the top address lands at the bottom of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| obl_en | input | 1 | 1: cache hits also trigger prefetch |
| acc_valid | input | 1 | Cache access (line address) presented |
| acc_addr | input | ADDR_W | Line address of the access |
| acc_hit | input | 1 | 1: the access hit in the cache |
| acc_ready | output | 1 | Access can be accepted (no demand outstanding) |
| mem_req_valid | output | 1 | Memory line request presented |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | ADDR_W | Requested line address |
| mem_req_tag | output | 1 | 0 demand, 1 prefetch |
| mem_rsp_valid | input | 1 | Memory reply valid |
| mem_rsp_tag | input | 1 | Tag of the reply, 0 demand, 1 prefetch |
| mem_rsp_data | input | DATA_W | Reply line data |
| fill_valid | output | 1 | Line delivered to the cache |
| fill_addr | output | ADDR_W | Line address of the fill |
| fill_data | output | DATA_W | Line data of the fill |
| fill_from_sb | output | 1 | 1: the fill came from the stream buffer |

## Verification
A buffer entry that is wrongly kept, wrongly lost or written twice shows up at the first later miss to that line. It gives a one-cycle fill where a demand request was due, or a demand request where a buffer fill was due. Stale prefetch data escaping a flush is found the same way. A prefetch queue that ignores its dedup or drop rules gives an extra or wrong prefetch request in the cycle the port frees up, usually one or two cycles after the reply that frees it. Wrong lookahead arithmetic gives a wrong request address in the very next request.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  typedef enum logic {
    TAG_DEMAND   = 1'b0,
    TAG_PREFETCH = 1'b1
  } mem_tag_e;
endpackage

// File: rtl/nbp_sbuf.sv
module nbp_sbuf #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_hit,
  input  logic              take,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q, vld_nx, lk_vec, chk_vec;
  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lk_vec[g]  = vld_q[g] && (tag_q[g] == lk_addr);
    assign chk_vec[g] = vld_q[g] && (tag_q[g] == chk_addr);
  end

  assign lk_hit  = |lk_vec;
  assign chk_hit = |chk_vec;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (lk_vec[i]) lk_data = lk_data | dat_q[i];
  end

  always_comb begin
    vld_nx = vld_q;
    if (take)  vld_nx = vld_nx & ~lk_vec;
    if (wr_en) vld_nx[ptr_q] = 1'b1;
    if (flush) vld_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_nx;
      if (flush)      ptr_q <= '0;
      else if (wr_en) ptr_q <= ptr_next(ptr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[ptr_q] <= wr_addr;
      dat_q[ptr_q] <= wr_data;
    end
  end

  AST_SB_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec)) else $error("duplicate stream buffer line"); // R8

  AST_SB_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit && !chk_hit)) else $error("entry survived flush"); // R6
endmodule

// File: rtl/nbp_reqsel.sv
module nbp_reqsel #(
  parameter int ADDR_W = 26
) (
  input  logic              dmd_req,
  input  logic [ADDR_W-1:0] dmd_addr,
  input  logic              pf_want,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_busy,
  input  logic              mem_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output nbp_pkg::mem_tag_e req_tag,
  output logic              dmd_issue,
  output logic              pf_issue
);
  logic pf_go;

  assign pf_go     = pf_want && !pf_busy && !dmd_req;
  assign req_valid = dmd_req || pf_go;
  assign req_addr  = dmd_req ? dmd_addr : pf_addr;
  assign req_tag   = dmd_req ? nbp_pkg::TAG_DEMAND : nbp_pkg::TAG_PREFETCH;
  assign dmd_issue = dmd_req && mem_ready;
  assign pf_issue  = pf_go && mem_ready;
endmodule

// File: rtl/nbp_prefetch.sv
module nbp_prefetch #(
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 32,
  parameter int SB_DEPTH  = 4,
  parameter int LOOKAHEAD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obl_en,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_hit,
  output logic              acc_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_tag,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_from_sb
);
  import nbp_pkg::*;

  function automatic logic [ADDR_W-1:0] blk_ahead(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(LOOKAHEAD);
  endfunction

  // state
  logic              dmd_busy, dmd_req;
  logic [ADDR_W-1:0] dmd_addr;
  logic              pf_want, pf_busy, pf_stale;
  logic [ADDR_W-1:0] pf_want_addr, pf_out_addr;

  // named events
  logic              acc_fire, miss_evt, sb_hit_evt, sb_miss_evt, obl_evt;
  logic              pf_trig, pf_dup, pf_queue;
  logic              dmd_rsp, pf_rsp, sb_wr;
  logic [ADDR_W-1:0] pf_tgt;
  logic              lk_hit, chk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              dmd_issue, pf_issue;
  mem_tag_e          req_tag;

  assign acc_ready   = !dmd_busy;
  assign acc_fire    = acc_valid && acc_ready;
  assign miss_evt    = acc_fire && !acc_hit;
  assign sb_hit_evt  = miss_evt && lk_hit;
  assign sb_miss_evt = miss_evt && !lk_hit;
  assign obl_evt     = acc_fire && acc_hit && obl_en;
  assign pf_trig     = miss_evt || obl_evt;
  assign pf_tgt      = blk_ahead(acc_addr);
  // after a flush nothing older counts as a duplicate
  assign pf_dup      = !sb_miss_evt &&
                       (chk_hit || (pf_busy && !pf_stale && pf_out_addr == pf_tgt));
  assign pf_queue    = pf_trig && !pf_dup;
  assign dmd_rsp     = mem_rsp_valid && (mem_rsp_tag == TAG_DEMAND);
  assign pf_rsp      = mem_rsp_valid && (mem_rsp_tag == TAG_PREFETCH);
  assign sb_wr       = pf_rsp && !pf_stale && !sb_miss_evt;

  nbp_sbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(SB_DEPTH)) u_sbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (acc_addr),
    .lk_hit   (lk_hit),
    .lk_data  (lk_data),
    .chk_addr (pf_tgt),
    .chk_hit  (chk_hit),
    .take     (sb_hit_evt),
    .flush    (sb_miss_evt),
    .wr_en    (sb_wr),
    .wr_addr  (pf_out_addr),
    .wr_data  (mem_rsp_data)
  );

  nbp_reqsel #(.ADDR_W(ADDR_W)) u_reqsel (
    .dmd_req   (dmd_req),
    .dmd_addr  (dmd_addr),
    .pf_want   (pf_want),
    .pf_addr   (pf_want_addr),
    .pf_busy   (pf_busy),
    .mem_ready (mem_req_ready),
    .req_valid (mem_req_valid),
    .req_addr  (mem_req_addr),
    .req_tag   (req_tag),
    .dmd_issue (dmd_issue),
    .pf_issue  (pf_issue)
  );

  assign mem_req_tag = req_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmd_busy     <= 1'b0;
      dmd_req      <= 1'b0;
      dmd_addr     <= '0;
      pf_want      <= 1'b0;
      pf_want_addr <= '0;
      pf_busy      <= 1'b0;
      pf_stale     <= 1'b0;
      pf_out_addr  <= '0;
      fill_valid   <= 1'b0;
      fill_addr    <= '0;
      fill_data    <= '0;
      fill_from_sb <= 1'b0;
    end else begin
      if (sb_miss_evt) begin
        dmd_busy <= 1'b1;
        dmd_req  <= 1'b1;
        dmd_addr <= acc_addr;
      end else begin
        if (dmd_rsp)   dmd_busy <= 1'b0;
        if (dmd_issue) dmd_req  <= 1'b0;
      end

      if (pf_queue) begin
        pf_want      <= 1'b1;
        pf_want_addr <= pf_tgt;
      end else if (sb_miss_evt || pf_issue) begin
        pf_want <= 1'b0;
      end

      if (pf_issue) begin
        pf_busy     <= 1'b1;
        pf_out_addr <= pf_want_addr;
        pf_stale    <= sb_miss_evt;
      end else if (pf_rsp) begin
        pf_busy  <= 1'b0;
        pf_stale <= 1'b0;
      end else if (sb_miss_evt && pf_busy) begin
        pf_stale <= 1'b1;
      end

      fill_valid <= sb_hit_evt || dmd_rsp;
      if (sb_hit_evt) begin
        fill_addr    <= acc_addr;
        fill_data    <= lk_data;
        fill_from_sb <= 1'b1;
      end else if (dmd_rsp) begin
        fill_addr    <= dmd_addr;
        fill_data    <= mem_rsp_data;
        fill_from_sb <= 1'b0;
      end
    end
  end

  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sb_miss_evt |=> (mem_req_valid && mem_req_tag == TAG_DEMAND &&
                     mem_req_addr == $past(acc_addr))) else $error("demand not first"); // R2

  AST_DEMAND_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_tag == TAG_DEMAND) |-> dmd_busy) else $error("orphan demand"); // R2

  AST_DEMAND_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_rsp |=> (fill_valid && !fill_from_sb && fill_addr == $past(dmd_addr)))
    else $error("demand fill wrong"); // R3

  AST_SB_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    sb_hit_evt |=> (fill_valid && fill_from_sb && fill_addr == $past(acc_addr) &&
                    !(mem_req_valid && mem_req_tag == TAG_DEMAND)))
    else $error("buffer fill wrong"); // R5

  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sb_miss_evt |=> !acc_ready) else $error("accepting during demand"); // R10
endmodule

// File: tb/sim_nbp_prefetch.sv
module sim_nbp_prefetch;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obl_en = 1'b0;
  logic acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_hit = 1'b0;
  logic acc_ready;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_req_tag;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_tag = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic fill_valid;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic fill_from_sb;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nbp_prefetch #(.ADDR_W(AW), .DATA_W(DW), .SB_DEPTH(2), .LOOKAHEAD(LA)) u0 (
    .clk(clk), .rst_n(rst_n), .obl_en(obl_en),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_hit(acc_hit), .acc_ready(acc_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_from_sb(fill_from_sb)
  );

  function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
    return {a, a ^ 8'hC3};
  endfunction

  function automatic logic [AW-1:0] ahead(input logic [AW-1:0] a);
    return AW'((int'(a) + LA) % 256);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic hit);
    acc_valid = 1'b1; acc_addr = a; acc_hit = hit;
    @(negedge clk);
    acc_valid = 1'b0; acc_hit = 1'b0;
  endtask

  task automatic expect_req(input logic tag, input logic [AW-1:0] a, input string req);
    check(req, {mem_req_valid, mem_req_tag, 22'd0, mem_req_addr}, {1'b1, tag, 22'd0, a});
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    check(req, {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic respond(input logic tag, input logic [DW-1:0] d);
    mem_rsp_valid = 1'b1; mem_rsp_tag = tag; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic expect_fill(input logic [AW-1:0] a, input logic src, input string req);
    check(req, {fill_valid, fill_from_sb, 6'd0, fill_addr, fill_data},
               {1'b1, src, 6'd0, a, mem_of(a)});
  endtask

  // buffer-missing miss with its demand and prefetch completed
  task automatic cold_miss(input logic [AW-1:0] a, input string req);
    access(a, 1'b0);
    check("R2", {31'd0, acc_ready}, 32'd0);
    expect_req(1'b0, a, req);
    expect_req(1'b1, ahead(a), (int'(a) + LA > 255) ? "R11" : "R4");
    expect_idle("R4");
    respond(1'b0, mem_of(a));
    expect_fill(a, 1'b0, "R3");
    check("R3", {31'd0, acc_ready}, 32'd1);
    respond(1'b1, mem_of(ahead(a)));
    check("R4", {31'd0, fill_valid}, 32'd0);
  endtask

  // miss expected to be served by the stream buffer
  task automatic sb_miss_hit(input logic [AW-1:0] a);
    access(a, 1'b0);
    expect_fill(a, 1'b1, "R5");
    check("R5", {31'd0, acc_ready}, 32'd1);
    expect_req(1'b1, ahead(a), (int'(a) + LA > 255) ? "R11" : "R5");
    respond(1'b1, mem_of(ahead(a)));
    check("R5", {31'd0, fill_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {29'd0, mem_req_valid, fill_valid, acc_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {29'd0, mem_req_valid, fill_valid, acc_ready}, 32'd1);

    // sweep: cold miss then a chain of buffer hits, including address wrap
    for (int k = 0; k < 9; k++) begin
      logic [AW-1:0] s;
      s = (k < 7) ? AW'(k * 37) : AW'(246 + k);
      cold_miss(s, "R2");
      for (int j = 1; j <= 3; j++) sb_miss_hit(AW'((int'(s) + j * LA) % 256));
    end

    // R10: access while a demand is outstanding is ignored
    access(8'd100, 1'b0);
    expect_req(1'b0, 8'd100, "R2");
    expect_req(1'b1, 8'd102, "R4");
    access(8'd50, 1'b0);
    expect_idle("R10");
    respond(1'b0, mem_of(8'd100));
    expect_fill(8'd100, 1'b0, "R10");
    expect_idle("R10");
    respond(1'b1, mem_of(8'd102));

    // R7: hit-triggered prefetch only in lookahead mode
    access(8'd60, 1'b1);
    expect_idle("R7");
    @(negedge clk);
    expect_idle("R7");
    obl_en = 1'b1;
    access(8'd60, 1'b1);
    expect_req(1'b1, 8'd62, "R7");
    respond(1'b1, mem_of(8'd62));
    check("R7", {31'd0, fill_valid}, 32'd0);
    sb_miss_hit(8'd62);

    // R8: duplicate targets are not prefetched
    access(8'd62, 1'b1);
    expect_idle("R8");
    @(negedge clk);
    expect_idle("R8");
    access(8'd70, 1'b1);
    expect_req(1'b1, 8'd72, "R7");
    access(8'd70, 1'b1);
    expect_idle("R8");
    respond(1'b1, mem_of(8'd72));
    expect_idle("R8");
    @(negedge clk);
    expect_idle("R8");

    // R9 / R6: queued prefetch dropped, stale reply discarded, buffer flushed
    access(8'd80, 1'b1);
    expect_req(1'b1, 8'd82, "R7");
    access(8'd90, 1'b1);
    expect_idle("R9");
    access(8'd120, 1'b0);
    expect_req(1'b0, 8'd120, "R2");
    expect_idle("R9");
    respond(1'b1, mem_of(8'd82));
    expect_req(1'b1, 8'd122, "R9");
    expect_idle("R9");
    respond(1'b0, mem_of(8'd120));
    expect_fill(8'd120, 1'b0, "R3");
    respond(1'b1, mem_of(8'd122));
    obl_en = 1'b0;
    cold_miss(8'd82, "R6");
    cold_miss(8'd72, "R6");
    sb_miss_hit(8'd74);

    // R5: consumed entry no longer hits
    cold_miss(8'd74, "R5");

    summary();
  end
endmodule